// File: doc/BRIEF.md
# Addressed Serial Setting Receiver

This block receives settings for a multi-function audio control device over a three-wire serial bus made of a data line, a bit clock and a frame-enable line. All three lines are brought into the system clock domain through synchronizers, and their edges are found from the synchronized samples. A frame opens when the enable line falls. The first two bits of the frame are a device address. If the address matches, any number of further bits may follow, and the block keeps only the most recent nine.

When the enable line rises at the end of an addressed frame that carried at least nine data bits, the nine kept bits are split into a three-bit function index and a six-bit value. The value is written into the register of that function. Each write raises a one-cycle update strobe together with the written index. Several devices can share the bus, because a frame with any other address is ignored. An enable fall made while the bit clock is high is reported as a framing error, and that frame is dropped.

Top module: `ssr_top`

## Requirements
- R1: After reset, all eight six-bit settings read zero and no update strobe is raised. Bits clocked before the first falling edge of the enable line are never committed.
- R2: One data bit is taken on each rising edge of the bit clock while a frame is open. The bit taken is the data line level synchronized in the same cycle.
- R3: The first two bits of a frame are the address. Only the order 1 then 0 (first bit received is 1) enables the frame. With any other address, every later bit up to the next enable fall is ignored.
- R4: After a matching address, the data stream may have any length of nine bits or more. Only the last nine bits received are used. Of these, the first three received form the function index (first received is the MSB), and the last six form the value (first received is the MSB).
- R5: If the enable line rises after a matching address but before nine data bits have been received, no setting changes and no strobe is raised.
- R6: Settings change only on a commit caused by a rising edge of the enable line, and only the register named by the index is written. Setting f occupies bits [6f+5:6f] of the settings output.
- R7: While the enable line is high, activity on the bit clock and data lines changes no setting and raises no strobe.
- R8: A falling edge of the enable line seen while the bit clock is high raises the frame error output for exactly one cycle. The frame that follows is discarded, and no commit takes place when the enable line rises.
- R9: Each commit raises the update strobe for exactly one cycle and shows the written function index in the same cycle.
- R10: Each falling edge of the enable line clears any earlier address match, so a frame with a wrong address that follows a good frame commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Serial bit clock, asynchronous |
| bus_dat_i | input | 1 | Serial data, asynchronous |
| bus_en_i | input | 1 | Frame enable, low while a frame is open, asynchronous |
| settings_o | output | 48 | Eight six-bit settings, function f at [6f+5:6f] |
| update_o | output | 1 | One-cycle pulse on each commit |
| update_sel_o | output | 3 | Function index written, valid with update_o |
| frame_err_o | output | 1 | One-cycle pulse when the enable line falls with the bit clock high |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. The settings stay stable in any cycle with no enable rise, the update and error pulses last exactly one cycle, the data-bit counter never passes nine, and no bit is taken while the enable line is high. Other behaviour can be shown only by whole bus scenarios: address matching and rejection, keeping the last nine bits of long streams, dropping short frames, ignoring bits before the first enable fall, and discarding a frame after a framing error. The bench covers these with directed frames and with random frames checked against a model that keeps the expected value of each function register.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int SEL_W    = 3;
    localparam int VAL_W    = 6;
    localparam int PAY_W    = SEL_W + VAL_W;
    localparam int NUM_FUNC = 1 << SEL_W;

    typedef struct packed {
        logic clk;
        logic dat;
        logic en;
    } lines_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [VAL_W-1:0] val;
    } payload_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } frame_state_t;

    function automatic payload_t split_payload(input logic [PAY_W-1:0] raw);
        payload_t p;
        p.sel = raw[PAY_W-1 -: SEL_W];
        p.val = raw[VAL_W-1:0];
        return p;
    endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync
    import ssr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t raw_i,
    output lines_t lvl_o,
    output lines_t rise_o,
    output lines_t fall_o
);
    localparam int NLINES = $bits(lines_t);

    logic [NLINES-1:0] raw_v;
    logic [NLINES-1:0] lvl_v;
    logic [NLINES-1:0] prev_v;

    assign raw_v = raw_i;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain     <= '0;
                prev_v[i] <= 1'b0;
            end else begin
                chain     <= {chain[STAGES-2:0], raw_v[i]};
                prev_v[i] <= chain[STAGES-1];
            end
        end
        assign lvl_v[i] = chain[STAGES-1];
    end

    assign lvl_o  = lvl_v;
    assign rise_o = lvl_v & ~prev_v;
    assign fall_o = ~lvl_v & prev_v;
endmodule

// File: rtl/ssr_frame.sv
module ssr_frame
    import ssr_pkg::*;
#(
    parameter int            ADDR_W     = 2,
    parameter logic [ADDR_W-1:0] ADDR_MATCH = 2'b10
) (
    input  logic     clk,
    input  logic     rst,
    input  lines_t   lvl_i,
    input  lines_t   rise_i,
    input  lines_t   fall_i,
    output logic     commit_o,
    output payload_t payload_o,
    output logic     frame_err_o
);
    localparam int AC_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
    localparam int DC_W = $clog2(PAY_W + 1);

    frame_state_t      state;
    logic [ADDR_W-1:0] addr_sh;
    logic [ADDR_W-1:0] addr_next;
    logic [AC_W-1:0]   acnt;
    logic [PAY_W-1:0]  shreg;
    logic [DC_W-1:0]   dcnt;
    logic              take_bit;

    assign take_bit  = rise_i.clk && (state == ST_ADDR || state == ST_DATA)
                       && !fall_i.en && !rise_i.en;
    assign addr_next = {addr_sh[ADDR_W-2:0], lvl_i.dat};

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            addr_sh     <= '0;
            acnt        <= '0;
            shreg       <= '0;
            dcnt        <= '0;
            frame_err_o <= 1'b0;
        end else begin
            frame_err_o <= 1'b0;
            if (fall_i.en) begin
                acnt <= '0;
                dcnt <= '0;
                if (lvl_i.clk) begin
                    frame_err_o <= 1'b1;
                    state       <= ST_IDLE;
                end else begin
                    state <= ST_ADDR;
                end
            end else if (rise_i.en) begin
                state <= ST_IDLE;
            end else if (take_bit) begin
                if (state == ST_ADDR) begin
                    addr_sh <= addr_next;
                    if (acnt == AC_W'(ADDR_W - 1))
                        state <= (addr_next == ADDR_MATCH) ? ST_DATA : ST_SKIP;
                    else
                        acnt <= acnt + 1'b1;
                end else begin
                    shreg <= {shreg[PAY_W-2:0], lvl_i.dat};
                    if (dcnt != DC_W'(PAY_W))
                        dcnt <= dcnt + 1'b1;
                end
            end
        end
    end

    assign commit_o  = rise_i.en && (state == ST_DATA) && (dcnt == DC_W'(PAY_W));
    assign payload_o = split_payload(shreg);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        dcnt <= DC_W'(PAY_W));
    assert_no_bit_enable_high_R7: assert property (@(posedge clk) disable iff (rst)
        lvl_i.en |-> !take_bit);
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);
endmodule

// File: rtl/ssr_bank.sv
module ssr_bank
    import ssr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      commit_i,
    input  payload_t                  payload_i,
    output logic [NUM_FUNC*VAL_W-1:0] settings_o,
    output logic                      update_o,
    output logic [SEL_W-1:0]          update_sel_o
);
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        logic [VAL_W-1:0] reg_q;
        always_ff @(posedge clk) begin
            if (rst)
                reg_q <= '0;
            else if (commit_i && payload_i.sel == SEL_W'(f))
                reg_q <= payload_i.val;
        end
        assign settings_o[f*VAL_W +: VAL_W] = reg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            update_o     <= 1'b0;
            update_sel_o <= '0;
        end else begin
            update_o <= commit_i;
            if (commit_i)
                update_sel_o <= payload_i.sel;
        end
    end

    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        update_o |=> !update_o);
endmodule

// File: rtl/ssr_top.sv
module ssr_top
    import ssr_pkg::*;
#(
    parameter int                ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] ADDR_MATCH  = 2'b10,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_clk_i,
    input  logic                      bus_dat_i,
    input  logic                      bus_en_i,
    output logic [NUM_FUNC*VAL_W-1:0] settings_o,
    output logic                      update_o,
    output logic [SEL_W-1:0]          update_sel_o,
    output logic                      frame_err_o
);
    lines_t   raw, lvl, rise, fall;
    logic     commit;
    payload_t payload;

    assign raw.clk = bus_clk_i;
    assign raw.dat = bus_dat_i;
    assign raw.en  = bus_en_i;

    ssr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_i(raw),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    ssr_frame #(.ADDR_W(ADDR_W), .ADDR_MATCH(ADDR_MATCH)) u_frame (
        .clk(clk), .rst(rst), .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
        .commit_o(commit), .payload_o(payload), .frame_err_o(frame_err_o)
    );

    ssr_bank u_bank (
        .clk(clk), .rst(rst), .commit_i(commit), .payload_i(payload),
        .settings_o(settings_o), .update_o(update_o), .update_sel_o(update_sel_o)
    );

    assert_settings_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !rise.en |=> $stable(settings_o));
    assert_no_commit_on_err_R8: assert property (@(posedge clk) disable iff (rst)
        !(frame_err_o && update_o));
endmodule

// File: tb/ssr_top_bench.sv
module ssr_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, bdat = 1'b0, ben = 1'b0;
    logic [47:0] settings;
    logic        upd, ferr;
    logic [2:0]  usel;

    int checks = 0, fails = 0;
    int strobes = 0, errs = 0;
    logic [2:0] last_sel = '0;
    logic [5:0] exp_set [8];

    always #4 clk = ~clk;

    ssr_top u_ssr_top (
        .clk(clk), .rst(rst), .bus_clk_i(bclk), .bus_dat_i(bdat), .bus_en_i(ben),
        .settings_o(settings), .update_o(upd), .update_sel_o(usel), .frame_err_o(ferr)
    );

    always @(posedge clk) begin
        if (!rst && upd) begin
            strobes  <= strobes + 1;
            last_sel <= usel;
        end
        if (!rst && ferr) errs <= errs + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] vec, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            bdat = vec[i];
            half();
            bclk = 1'b1;
            half();
            bclk = 1'b0;
        end
    endtask

    function automatic logic [47:0] exp_flat();
        logic [47:0] r;
        for (int f = 0; f < 8; f++) r[f*6 +: 6] = exp_set[f];
        return r;
    endfunction

    function automatic bit will_commit(input logic [1:0] a, input int nd);
        return (a == 2'b10) && (nd >= 9);
    endfunction

    task automatic frame(input logic [1:0] a, input logic [47:0] d, input int nd, input string tag);
        int s0 = strobes;
        bit  c = will_commit(a, nd);
        logic [63:0] vec = ({62'd0, a} << nd) | (64'(d) & ((64'd1 << nd) - 1));
        bclk = 1'b0;
        half();
        ben = 1'b0;
        half();
        send_bits(vec, nd + 2);
        half();
        ben = 1'b1;
        repeat (10) @(negedge clk);
        if (c) exp_set[d[8:6]] = d[5:0];
        check(settings == exp_flat(), {tag, " settings R6"}, settings, exp_flat());
        check(strobes - s0 == (c ? 1 : 0), {tag, " strobe count R9"}, strobes - s0, c ? 1 : 0);
        if (c) check(last_sel == d[8:6], {tag, " strobe index R9"}, last_sel, d[8:6]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0, e0;
        void'($urandom(32'd2024));
        for (int f = 0; f < 8; f++) exp_set[f] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(settings == 48'd0, "R1 settings zero", settings, 0);
        check(upd == 1'b0, "R1 no strobe", upd, 0);
        // R1: enable held low from reset, no fall seen: bits must not commit
        s0 = strobes;
        send_bits(64'b10_101_110011, 11);
        half();
        ben = 1'b1;
        repeat (10) @(negedge clk);
        check(settings == 48'd0 && strobes == s0, "R1 no commit before first fall", settings, 0);

        // R2 R4 basic nine-bit frames
        frame(2'b10, 48'b011_101010, 9, "R2 basic");
        frame(2'b10, 48'b111_000001, 9, "R4 top index");
        frame(2'b10, 48'b000_111111, 9, "R4 index zero");
        // R4 long stream, last nine kept
        frame(2'b10, 48'hABCDE_0_1_5B, 29, "R4 long stream");
        // R5 short frames
        frame(2'b10, 48'b10101010, 8, "R5 eight bits");
        frame(2'b10, 48'd0, 0, "R5 zero bits");
        // R3 bad addresses
        frame(2'b01, 48'b010_110110, 9, "R3 addr 01");
        frame(2'b11, 48'b010_110110, 12, "R3 addr 11");
        frame(2'b00, 48'b010_110110, 9, "R3 addr 00");
        // R10 good frame then bad address frame
        frame(2'b10, 48'b100_011011, 9, "R10 good");
        frame(2'b11, 48'b100_100100, 9, "R10 bad after good");

        // R7 activity while enable high
        s0 = strobes;
        for (int i = 0; i < 20; i++) begin
            bdat = i[0];
            half();
            bclk = 1'b1;
            half();
            bclk = 1'b0;
        end
        repeat (10) @(negedge clk);
        check(settings == exp_flat() && strobes == s0, "R7 ignored while enable high", settings, exp_flat());

        // R8 enable falls with clock high
        s0 = strobes;
        e0 = errs;
        bclk = 1'b1;
        half();
        ben = 1'b0;
        half();
        bclk = 1'b0;
        send_bits(64'b10_010_101010, 11);
        half();
        ben = 1'b1;
        repeat (10) @(negedge clk);
        check(errs - e0 == 1, "R8 error pulse", errs - e0, 1);
        check(strobes == s0 && settings == exp_flat(), "R8 frame discarded", settings, exp_flat());
        frame(2'b10, 48'b010_000111, 9, "R8 recovery");

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic [1:0]  a  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b10;
            int          nd = $urandom % 16;
            logic [47:0] d  = {16'($urandom), 32'($urandom)};
            frame(a, d, nd, "R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule